// File: doc/BRIEF.md
# Add/Subtract Condition Flag Generator

This block adds or subtracts two operand words in one combinational pass. It returns the result together with four condition flags: negative, zero, carry and signed overflow. A single select input picks the operation. A subtract is formed as A plus the inverted B plus one. The adder itself is only as wide as the operands.

The carry and overflow flags come only from the sign bits of the two operands and of the result. No extra sum bit is used to form them. For a subtract, the carry flag is the inverse of the borrow: it reads 1 when no borrow occurred. The block is meant to sit in an execute stage ahead of a flag register that the surrounding logic owns. It has no clock, no state and no reset.

Top module: `flag_addsub`

## Requirements
- R1: With `sub_i` = 0, `result_o` equals `a_i + b_i` modulo 2^WIDTH.
- R2: With `sub_i` = 1, `result_o` equals `a_i - b_i` modulo 2^WIDTH.
- R3: `neg_o` equals the top bit (bit WIDTH-1) of `result_o`.
- R4: `zero_o` is 1 exactly when every bit of `result_o` is 0.
- R5: For an add, `carry_o` is 1 exactly when the unsigned sum does not fit in WIDTH bits. This is bit WIDTH of a (WIDTH+1)-bit sum.
- R6: For a subtract, `carry_o` is 1 exactly when `a_i` >= `b_i` as unsigned numbers, meaning no borrow occurred. In particular, 0 - 0 gives a carry of 1.
- R7: For an add, `ovf_o` is 1 exactly when the two's-complement sum of the operands falls outside the signed WIDTH-bit range.
- R8: For a subtract, `ovf_o` is 1 exactly when the two's-complement difference falls outside the signed WIDTH-bit range.
- R9: All outputs are combinational functions of the present inputs and settle within the same cycle. No input history affects them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand (minuend for a subtract) |
| b_i | input | WIDTH | Second operand (subtrahend for a subtract) |
| sub_i | input | 1 | Operation select: 0 = add, 1 = subtract |
| result_o | output | WIDTH | Sum or difference |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry out for an add, no-borrow for a subtract |
| ovf_o | output | 1 | Signed overflow |

## Verification
Every result is due in the same cycle as its stimulus, with no register in between. The bench drives the operands and the select on the falling clock edge. It reads all five outputs one nanosecond later, well before the next rising edge. The expected flags come from a (WIDTH+1)-bit unsigned sum and from a wider signed sum. Both are computed in the bench, so the sign-bit logic is checked against arithmetic it does not share. Sequences that repeat an operand pair after unrelated traffic confirm that no earlier input leaves a trace.

// File: rtl/flag_addsub_pkg.sv
package flag_addsub_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
    logic ovf;
  } flags_t;
endpackage

// File: rtl/flag_addsub_core.sv
module flag_addsub_core #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o
);
  logic [WIDTH-1:0] b_eff;

  // subtract = a + ~b + 1
  assign b_eff = b_i ^ {WIDTH{sub_i}};
  assign sum_o = a_i + b_eff + {{(WIDTH-1){1'b0}}, sub_i};

  always_comb begin
    if (sub_i == 1'b0)
      AST_ADD_RESULT: assert (sum_o == WIDTH'(a_i + b_i)) else $error("add result");   // R1
    else
      AST_SUB_RESULT: assert (sum_o == WIDTH'(a_i - b_i)) else $error("sub result");   // R2
  end
endmodule

// File: rtl/flag_addsub_zero.sv
module flag_addsub_zero #(
  parameter int WIDTH = 32,
  parameter int CHUNK = 8
) (
  input  logic [WIDTH-1:0] data_i,
  output logic             zero_o
);
  localparam int NCHUNK = (WIDTH + CHUNK - 1) / CHUNK;
  localparam int PADW   = NCHUNK * CHUNK;

  logic [PADW-1:0]   padded;
  logic [NCHUNK-1:0] any_set;

  assign padded = PADW'(data_i);

  for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
    assign any_set[g] = |padded[g*CHUNK +: CHUNK];
  end

  assign zero_o = ~|any_set;

  always_comb begin
    AST_ZERO_FLAG: assert (zero_o == (data_i == '0)) else $error("zero flag");   // R4
  end
endmodule

// File: rtl/flag_addsub_flags.sv
module flag_addsub_flags (
  input  logic sign_a_i,
  input  logic sign_b_i,
  input  logic sign_r_i,
  input  logic sub_i,
  output logic carry_o,
  output logic ovf_o
);
  logic add_c, sub_c, add_v, sub_v;

  // carry out of the top bit, rebuilt from the three sign bits
  assign add_c = (sign_a_i & sign_b_i) | ((sign_a_i | sign_b_i) & ~sign_r_i);
  // no-borrow: majority of a, ~b, ~r
  assign sub_c = (sign_a_i & ~sign_b_i) | (sign_a_i & ~sign_r_i) | (~sign_b_i & ~sign_r_i);
  assign add_v = (sign_a_i & sign_b_i & ~sign_r_i) | (~sign_a_i & ~sign_b_i & sign_r_i);
  assign sub_v = (sign_a_i & ~sign_b_i & ~sign_r_i) | (~sign_a_i & sign_b_i & sign_r_i);

  assign carry_o = sub_i ? sub_c : add_c;
  assign ovf_o   = sub_i ? sub_v : add_v;
endmodule

// File: rtl/flag_addsub.sv
module flag_addsub
  import flag_addsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] result_o,
  output logic             neg_o,
  output logic             zero_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  op_e              op;
  logic [WIDTH-1:0] sum;
  flags_t           flags;

  assign op = op_e'(sub_i);

  flag_addsub_core #(.WIDTH(WIDTH)) u_core (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (op == OP_SUB),
    .sum_o (sum)
  );

  flag_addsub_zero #(.WIDTH(WIDTH)) u_zero (
    .data_i (sum),
    .zero_o (flags.zero)
  );

  flag_addsub_flags u_flags (
    .sign_a_i (a_i[MSB]),
    .sign_b_i (b_i[MSB]),
    .sign_r_i (sum[MSB]),
    .sub_i    (op == OP_SUB),
    .carry_o  (flags.carry),
    .ovf_o    (flags.ovf)
  );

  assign flags.neg = sum[MSB];

  assign result_o = sum;
  assign neg_o    = flags.neg;
  assign zero_o   = flags.zero;
  assign carry_o  = flags.carry;
  assign ovf_o    = flags.ovf;

  // Cross-checks against wide arithmetic that shares no logic with the sign-bit terms
  logic [WIDTH:0]   wide_add;
  logic signed [WIDTH+1:0] s_add, s_sub;
  logic signed [WIDTH+1:0] s_max, s_min;

  always_comb begin
    wide_add = {1'b0, a_i} + {1'b0, b_i};
    s_add = $signed({{2{a_i[MSB]}}, a_i}) + $signed({{2{b_i[MSB]}}, b_i});
    s_sub = $signed({{2{a_i[MSB]}}, a_i}) - $signed({{2{b_i[MSB]}}, b_i});
    s_max = $signed({3'b000, {(WIDTH-1){1'b1}}});
    s_min = -s_max - 1;
    AST_NEG_FLAG: assert (neg_o == result_o[MSB]) else $error("neg flag");   // R3
    if (!sub_i) begin
      AST_ADD_CARRY: assert (carry_o == wide_add[WIDTH]) else $error("add carry");   // R5
      AST_ADD_OVERFLOW: assert (ovf_o == (s_add > s_max || s_add < s_min)) else $error("add ovf");   // R7
    end else begin
      AST_SUB_CARRY: assert (carry_o == (a_i >= b_i)) else $error("sub carry");   // R6
      AST_SUB_OVERFLOW: assert (ovf_o == (s_sub > s_max || s_sub < s_min)) else $error("sub ovf");   // R8
    end
  end
endmodule

// File: tb/flag_addsub_tb.sv
module flag_addsub_tb;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic sub, neg, zero, carry, ovf;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  flag_addsub #(.WIDTH(W)) u_dut (
    .a_i(a), .b_i(b), .sub_i(sub),
    .result_o(res), .neg_o(neg), .zero_o(zero), .carry_o(carry), .ovf_o(ovf)
  );

  task automatic check(string req, string what, logic [W-1:0] got, logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // Apply on the falling edge, sample 1 ns later: the outputs are due in the same cycle (R9)
  task automatic run_op(logic [W-1:0] x, logic [W-1:0] y, logic s);
    logic [W:0] u;
    logic signed [W+1:0] sv, smax, smin;
    @(negedge clk);
    a = x; b = y; sub = s;
    #1;
    u    = s ? ({1'b0, x} + {1'b0, ~y} + 1) : ({1'b0, x} + {1'b0, y});
    sv   = s ? ($signed({{2{x[W-1]}}, x}) - $signed({{2{y[W-1]}}, y}))
             : ($signed({{2{x[W-1]}}, x}) + $signed({{2{y[W-1]}}, y}));
    smax = $signed({3'b000, {(W-1){1'b1}}});
    smin = -smax - 1;
    check(s ? "R2" : "R1", "result", res, u[W-1:0]);
    check("R3", "neg", W'(neg), W'(u[W-1]));
    check("R4", "zero", W'(zero), W'(u[W-1:0] == '0));
    if (s) check("R6", "carry", W'(carry), W'(x >= y));
    else   check("R5", "carry", W'(carry), W'(u[W]));
    check(s ? "R8" : "R7", "ovf", W'(ovf), W'(sv > smax || sv < smin));
  endtask

  task automatic t_reset_state();
    // inputs held at zero during reset: 0 + 0
    #1;
    check("R4", "reset zero", W'(zero), W'(1));
    check("R1", "reset result", res, '0);
    check("R5", "reset carry", W'(carry), '0);
  endtask

  task automatic t_add_corners();
    run_op(32'h7FFF_FFFF, 32'h1, 1'b0);   // R7 positive overflow
    check("R7", "7fffffff+1 ovf", W'(ovf), W'(1));
    run_op(32'hFFFF_FFFF, 32'h1, 1'b0);   // R5 carry, zero
    check("R5", "ffffffff+1 carry", W'(carry), W'(1));
    run_op(32'h8000_0000, 32'h8000_0000, 1'b0);
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run_op(32'h0, 32'h0, 1'b0);
  endtask

  task automatic t_sub_corners();
    run_op(32'h8000_0000, 32'h1, 1'b1);   // R8 negative overflow
    check("R8", "80000000-1 ovf", W'(ovf), W'(1));
    run_op(32'h0, 32'h0, 1'b1);
    check("R6", "0-0 carry", W'(carry), W'(1));
    run_op(32'h0, 32'h1, 1'b1);
    check("R6", "0-1 borrow", W'(carry), W'(0));
    run_op(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    run_op(32'h1234_5678, 32'h1234_5678, 1'b1);
  endtask

  task automatic t_history();
    // R9: same pair after unrelated traffic gives the same outputs
    logic [W-1:0] r0;
    logic c0, v0;
    run_op(32'h4000_0000, 32'h4000_0000, 1'b0);
    r0 = res; c0 = carry; v0 = ovf;
    run_op(32'hFFFF_FFFF, 32'h0000_0001, 1'b1);
    run_op(32'h4000_0000, 32'h4000_0000, 1'b0);
    check("R9", "repeat result", res, r0);
    check("R9", "repeat flags", W'({c0, v0}), W'({carry, ovf}));
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] x, y;
      x = $urandom();
      y = (i % 7 == 0) ? x : $urandom();
      if (i % 11 == 0) y = {x[W-1], y[W-2:0]};
      run_op(x, y, logic'(i % 2));
    end
  endtask

  initial begin
    a = '0; b = '0; sub = 1'b0;
    repeat (3) @(posedge clk);
    t_reset_state();
    rst_ni = 1'b1;
    t_add_corners();
    t_sub_corners();
    t_history();
    t_random();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule